// File: doc/BRIEF.md
# Serial Clock Phase Generator for a Two-Wire Bus Master

This block produces the clock line of a two-wire (I2C) bus master, together with the moment at which the data line is allowed to move. Each clock period has a low phase and a high phase. Their lengths come from two 8-bit counts: a phase lasts four system clocks per count plus two. A third count sets how long the data line waits after each falling clock edge before it takes the next bit. If that wait would reach the rising edge, it is clamped so that the data line still settles one system clock before the clock rises.

A controller above this block supplies the next bit on `bit_in` and uses three one-clock strobes to pace its own sequencing: one at the falling edge, one at the data update and one at the rising edge. Both lines are open-drain levels, where 1 means released. When `en` is low, both lines are released and the timing state is cleared. The three counts are captured only at the falling edge that opens each period. A controller can therefore write the counts for the next period at any time during the current one.

The captured-count registers take their reset values from parameters: 0x3F for both phase counts and 0x01 for the hold count.

Top module: `sclk_phase_gen`

## Requirements
- R1: While `en` is low, `scl_o` and `sda_o` are 1 from the next clock edge on, and none of `fall_stb`, `upd_stb`, `rise_stb` is asserted.
- R2: At the first clock edge that samples `en` high after it was low, `scl_o` goes to 0 and `fall_stb` is 1 for that cycle.
- R3: The low phase of `scl_o` lasts 4*lo+2 system clocks, where lo is `cfg_lo` as captured at the falling edge. `rise_stb` is 1 in the first cycle with `scl_o` high.
- R4: The high phase lasts 4*hi+2 clocks, with hi taken from `cfg_hi`, so a full period lasts 4*(lo+hi)+4 clocks. The next `fall_stb` comes in the first cycle of the next low phase.
- R5: `sda_o` takes the value of `bit_in` that is present at the update edge. It changes hold+2 clocks after the cycle in which `fall_stb` is set, where hold is `cfg_hold`, and `upd_stb` is 1 in that cycle.
- R6: When hold+2 is equal to or greater than 4*lo+2, the update instead comes 4*lo+1 clocks after the falling edge, which is one clock before `scl_o` rises.
- R7: While enabled, `sda_o` changes only in a cycle where `upd_stb` is 1.
- R8: A change of `cfg_lo`, `cfg_hi` or `cfg_hold` during a period does not alter that period's timing. The new values take effect from the next falling edge.
- R9: Each strobe is one clock wide and occurs exactly once per SCL period. No two strobes are asserted in the same cycle.
- R10: During reset, `scl_o` and `sda_o` are 1 and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low releases both lines and clears timing |
| cfg_lo | input | 8 | Low-phase count (phase = 4*N+2 clocks) |
| cfg_hi | input | 8 | High-phase count (phase = 4*N+2 clocks) |
| cfg_hold | input | 8 | Data hold count (update at N+2 clocks after fall) |
| bit_in | input | 1 | Next data bit, sampled at the update point |
| scl_o | output | 1 | Clock line level (1 = released) |
| sda_o | output | 1 | Data line level (1 = released, 0 = pulled low) |
| fall_stb | output | 1 | One-clock strobe at each SCL falling edge |
| upd_stb | output | 1 | One-clock strobe when `sda_o` is updated |
| rise_stb | output | 1 | One-clock strobe at each SCL rising edge |

## Verification
The bench aims at the smallest period (both counts zero, a four-clock period). A counter that is off by one shows up there at once as a shortened phase, or as an update strobe that lands on the rising edge. It drives hold counts well past the low phase to test the clamp; an unclamped design would move the data line while SCL is high, or never update it at all. It rewrites all three counts in the second cycle of a period and checks that the old lengths still apply in that period and the new ones in the next, which catches a design that reads its configuration live. It also drops enable in the middle of a period to check that both lines are released and that a fresh falling edge opens the next run.

// File: rtl/sclg_pkg.sv
package sclg_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } sclg_phase_e;

endpackage

// File: rtl/sclg_cfg_latch.sv
module sclg_cfg_latch #(
   parameter int          CFG_W    = 8,
   parameter int          CNT_W    = CFG_W + 2,
   parameter logic [7:0]  DEF_LO   = 8'h3F,
   parameter logic [7:0]  DEF_HI   = 8'h3F,
   parameter logic [7:0]  DEF_HOLD = 8'h01,
   parameter bit          CLAMP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] cfg_lo,
   input  logic [CFG_W-1:0] cfg_hi,
   input  logic [CFG_W-1:0] cfg_hold,
   output logic [CNT_W-1:0] lo_last,
   output logic [CNT_W-1:0] hi_last,
   output logic [CNT_W-1:0] upd_at
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < CFG_W + 2) begin : g_bad_width
      $error("sclg_cfg_latch: CNT_W must be at least CFG_W + 2");
   end

   // last counter value of each phase (phase length minus one = 4N+1)
   logic [CNT_W-1:0] lo_last_d, hi_last_d, upd_at_d;
   logic [CNT_W-1:0] hold_cmp, lo_cmp_max;

   assign lo_last_d  = {cfg_lo, 2'b01};
   assign hi_last_d  = {cfg_hi, 2'b01};
   assign hold_cmp   = CNT_W'(cfg_hold) + ONE;
   assign lo_cmp_max = {cfg_lo, 2'b00};

   if (CLAMP_EN) begin : g_clamp
      assign upd_at_d = (hold_cmp > lo_cmp_max) ? lo_cmp_max : hold_cmp;
   end else begin : g_free
      assign upd_at_d = hold_cmp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_last <= {CNT_W'(DEF_LO) << 2} | ONE;
         hi_last <= {CNT_W'(DEF_HI) << 2} | ONE;
         upd_at  <= CNT_W'(DEF_HOLD) + ONE;
      end else if (load) begin
         lo_last <= lo_last_d;
         hi_last <= hi_last_d;
         upd_at  <= upd_at_d;
      end
   end

endmodule

// File: rtl/sclg_phase_ctr.sv
module sclg_phase_ctr
   import sclg_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] lo_last,
   input  logic [CNT_W-1:0] hi_last,
   output logic             load,
   output sclg_phase_e      phase,
   output logic [CNT_W-1:0] cnt,
   output logic             scl_o,
   output logic             fall_stb,
   output logic             rise_stb
);

   logic lo_end;

   assign load   = en && ((phase == PH_IDLE) || ((phase == PH_HIGH) && (cnt == hi_last)));
   assign lo_end = (phase == PH_LOW) && (cnt == lo_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt      <= '0;
         scl_o    <= 1'b1;
         fall_stb <= 1'b0;
         rise_stb <= 1'b0;
      end else if (!en) begin
         phase    <= PH_IDLE;
         cnt      <= '0;
         scl_o    <= 1'b1;
         fall_stb <= 1'b0;
         rise_stb <= 1'b0;
      end else if (load) begin
         phase    <= PH_LOW;
         cnt      <= '0;
         scl_o    <= 1'b0;
         fall_stb <= 1'b1;
         rise_stb <= 1'b0;
      end else if (lo_end) begin
         phase    <= PH_HIGH;
         cnt      <= '0;
         scl_o    <= 1'b1;
         fall_stb <= 1'b0;
         rise_stb <= 1'b1;
      end else begin
         cnt      <= cnt + CNT_W'(1);
         fall_stb <= 1'b0;
         rise_stb <= 1'b0;
      end
   end

   assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (scl_o && !fall_stb && !rise_stb));

   assert_fall_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> (!scl_o && $past(scl_o)));

   assert_low_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOW) |-> (cnt <= lo_last));

   assert_rise_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> (scl_o && !$past(scl_o)));

endmodule

// File: rtl/sclg_sda_drv.sv
module sclg_sda_drv #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             in_low,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] upd_at,
   input  logic             bit_in,
   output logic             sda_o,
   output logic             upd_stb
);

   logic hit;
   assign hit = in_low && (cnt == upd_at);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_o   <= 1'b1;
         upd_stb <= 1'b0;
      end else if (!en) begin
         sda_o   <= 1'b1;
         upd_stb <= 1'b0;
      end else if (hit) begin
         sda_o   <= bit_in;
         upd_stb <= 1'b1;
      end else begin
         upd_stb <= 1'b0;
      end
   end

   assert_sda_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && en && !upd_stb) |-> $stable(sda_o));

   assert_upd_takes_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |-> (sda_o == $past(bit_in)));

endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen
   import sclg_pkg::*;
#(
   parameter int          CFG_W    = 8,
   parameter logic [7:0]  DEF_LO   = 8'h3F,
   parameter logic [7:0]  DEF_HI   = 8'h3F,
   parameter logic [7:0]  DEF_HOLD = 8'h01,
   parameter bit          CLAMP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CFG_W-1:0] cfg_lo,
   input  logic [CFG_W-1:0] cfg_hi,
   input  logic [CFG_W-1:0] cfg_hold,
   input  logic             bit_in,
   output logic             scl_o,
   output logic             sda_o,
   output logic             fall_stb,
   output logic             upd_stb,
   output logic             rise_stb
);

   localparam int CNT_W = CFG_W + 2;

   if (CFG_W < 2 || CFG_W > 8) begin : g_bad_cfg
      $error("sclk_phase_gen: CFG_W must lie in 2..8");
   end

   logic             load;
   sclg_phase_e      phase;
   logic [CNT_W-1:0] cnt, lo_last, hi_last, upd_at;

   sclg_cfg_latch #(
      .CFG_W    (CFG_W),
      .CNT_W    (CNT_W),
      .DEF_LO   (DEF_LO),
      .DEF_HI   (DEF_HI),
      .DEF_HOLD (DEF_HOLD),
      .CLAMP_EN (CLAMP_EN)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .cfg_lo   (cfg_lo),
      .cfg_hi   (cfg_hi),
      .cfg_hold (cfg_hold),
      .lo_last  (lo_last),
      .hi_last  (hi_last),
      .upd_at   (upd_at)
   );

   sclg_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .lo_last  (lo_last),
      .hi_last  (hi_last),
      .load     (load),
      .phase    (phase),
      .cnt      (cnt),
      .scl_o    (scl_o),
      .fall_stb (fall_stb),
      .rise_stb (rise_stb)
   );

   sclg_sda_drv #(.CNT_W(CNT_W)) u_sda (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .in_low   (phase == PH_LOW),
      .cnt      (cnt),
      .upd_at   (upd_at),
      .bit_in   (bit_in),
      .sda_o    (sda_o),
      .upd_stb  (upd_stb)
   );

   assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fall_stb, upd_stb, rise_stb}));

   assert_upd_before_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |-> !scl_o);

endmodule

// File: tb/tb_sclk_phase_gen.sv
module tb_sclk_phase_gen;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] cfg_lo = 8'd0, cfg_hi = 8'd0, cfg_hold = 8'd0;
   logic       bit_in = 1'b1;
   logic       scl_o, sda_o, fall_stb, upd_stb, rise_stb;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sclk_phase_gen dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_hold(cfg_hold),
      .bit_in(bit_in), .scl_o(scl_o), .sda_o(sda_o),
      .fall_stb(fall_stb), .upd_stb(upd_stb), .rise_stb(rise_stb)
   );

   function automatic int lo_len(input int lo); return 4 * lo + 2; endfunction
   function automatic int hi_len(input int hi); return 4 * hi + 2; endfunction
   function automatic int upd_delay(input int lo, input int hold);
      return (hold + 2 < lo_len(lo) - 1) ? hold + 2 : lo_len(lo) - 1;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // disable, check idle lines, load config, enable, check first falling edge
   task automatic start_run(input int lo, input int hi, input int hold, input bit b);
      en = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (i > 0)
            chk(scl_o && sda_o && !fall_stb && !upd_stb && !rise_stb, "R1", "idle lines",
                {scl_o, sda_o, fall_stb, upd_stb, rise_stb}, 5'b11000);
      end
      cfg_lo = 8'(lo); cfg_hi = 8'(hi); cfg_hold = 8'(hold); bit_in = b;
      en = 1'b1;
      @(negedge clk);
      chk(fall_stb && !scl_o, "R2", "first edge after enable", {fall_stb, scl_o}, 2'b10);
   endtask

   // called at the negedge where fall_stb is seen; measures one period
   task automatic run_period(input int lo, input int hi, input int hold, input bit b,
                             input bit prev_sda, input int nlo, input int nhi,
                             input int nhold, input bit nb, input string tag);
      int per   = lo_len(lo) + hi_len(hi);
      int u_exp = upd_delay(lo, hold);
      int u_at = -1, r_at = -1, nf = 0, nu = 0, nr = 0;
      int bad_scl = 0, bad_sda = 0;
      for (int k = 1; k <= per; k++) begin
         @(negedge clk);
         if (k == 1) begin
            cfg_lo = 8'(nlo); cfg_hi = 8'(nhi); cfg_hold = 8'(nhold);
         end
         if (k < per) begin
            if (fall_stb) nf++;
            if (upd_stb) begin nu++; if (u_at < 0) u_at = k; end
            if (rise_stb) begin nr++; if (r_at < 0) r_at = k; end
            if (scl_o != (k >= lo_len(lo))) bad_scl++;
            if (sda_o != ((u_at >= 0) ? b : prev_sda)) bad_sda++;
            if (u_at >= 0) bit_in = nb;
         end else begin
            chk(fall_stb && !scl_o, {"R4 ", tag}, "next fall at period end", fall_stb, 1);
         end
      end
      chk(r_at == lo_len(lo), {"R3 ", tag}, "rise cycle", r_at, lo_len(lo));
      chk(bad_scl == 0, {"R3 R4 ", tag}, "scl shape mismatches", bad_scl, 0);
      chk(u_at == u_exp, (hold + 2 >= lo_len(lo)) ? {"R6 ", tag} : {"R5 ", tag},
          "update cycle", u_at, u_exp);
      chk(bad_sda == 0, {"R5 R7 ", tag}, "sda mismatches", bad_sda, 0);
      chk(nf == 0 && nu == 1 && nr == 1, "R9", "strobe counts f*100+u*10+r",
          nf * 100 + nu * 10 + nr, 11);
   endtask

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired: actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
      summary();
   end

   initial begin
      void'($urandom(32'd4711));
      #(CLK_PERIOD * 2 + 1);
      chk(scl_o && sda_o && !fall_stb && !upd_stb && !rise_stb, "R10", "reset outputs",
          {scl_o, sda_o, fall_stb, upd_stb, rise_stb}, 5'b11000);
      @(negedge clk);
      rst_n = 1'b1;

      // smallest period, clamp active (hold 0 -> 2 exceeds 1)
      start_run(0, 0, 0, 1'b0);
      run_period(0, 0, 0, 1'b0, 1'b1, 0, 0, 0, 1'b1, "min");
      // mid-hold directed
      start_run(3, 2, 5, 1'b0);
      run_period(3, 2, 5, 1'b0, 1'b1, 3, 2, 5, 1'b0, "mid");
      // large hold clamped
      start_run(2, 1, 200, 1'b0);
      run_period(2, 1, 200, 1'b0, 1'b1, 2, 1, 200, 1'b1, "clamp");
      // hold exactly at the clamp boundary: 4*lo = hold+1
      start_run(2, 0, 7, 1'b0);
      run_period(2, 0, 7, 1'b0, 1'b1, 2, 0, 7, 1'b0, "edge");
      // symmetric default-like setting, half-period hold
      start_run(63, 63, 31, 1'b0);
      run_period(63, 63, 31, 1'b0, 1'b1, 63, 63, 31, 1'b0, "sym");

      // mid-period rewrite: R8 old values hold, then the new values
      start_run(4, 3, 8, 1'b0);
      run_period(4, 3, 8, 1'b0, 1'b1, 1, 5, 0, 1'b1, "R8 old");
      run_period(1, 5, 0, 1'b1, 1'b0, 1, 5, 0, 1'b0, "R8 new");

      // disable mid-period: lines released, restart opens with a fall
      start_run(5, 5, 3, 1'b0);
      repeat (8) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk(scl_o && sda_o && !fall_stb && !upd_stb && !rise_stb, "R1", "release mid-period",
          {scl_o, sda_o, fall_stb, upd_stb, rise_stb}, 5'b11000);
      start_run(1, 1, 1, 1'b0);
      run_period(1, 1, 1, 1'b0, 1'b1, 1, 1, 1, 1'b0, "restart");

      // random chains of two periods with a rewrite in between
      for (int t = 0; t < 25; t++) begin
         int lo = $urandom_range(0, 20), hi = $urandom_range(0, 20);
         int ho = $urandom_range(0, 90);
         int nlo = $urandom_range(0, 20), nhi = $urandom_range(0, 20);
         int nho = $urandom_range(0, 90);
         bit b0 = 1'($urandom_range(0, 1)), b1 = 1'($urandom_range(0, 1));
         start_run(lo, hi, ho, b0);
         run_period(lo, hi, ho, b0, 1'b1, nlo, nhi, nho, b1, "R8 rnd1");
         run_period(nlo, nhi, nho, b1, b0, nlo, nhi, nho, b1, "R8 rnd2");
      end

      en = 1'b0;
      @(negedge clk);
      summary();
   end

endmodule